// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block decides which of three operating modes a bus transceiver is in: normal (transmit and receive), standby (low power, bus lines pulled to ground) or power-off (bus lines left floating). It watches a host standby pin and two pairs of digital comparator outputs, one pair for the core supply and one pair for the I/O supply. Each pair reports "below the detection threshold" and "above the recovery threshold". The comparator outputs are filtered in time to produce an undervoltage flag per supply. The standby pin is synchronised and debounced, with a debounce time that depends on the current mode.

The mode follows a fixed priority. A core-supply fault forces power-off. An I/O-supply fault forces standby. With both supplies healthy, the debounced pin selects normal or standby. Power-off is left only through standby. A power-on status flag records that the block has come out of power-off since it last left normal mode. The block drives enables for the transmitter, the receiver and the bus termination. It also gates the receive-data and error-indication paths toward the host.

Top module: `xcvr_mode_ctrl`

## Requirements
- R1: `mode_o` encodes 2'b00 = power-off, 2'b01 = standby, 2'b10 = normal. `tx_allow_o` and `rx_allow_o` are high only in normal. `term_gnd_o` is high only in standby. `bus_hiz_o` is high only in power-off.
- R2: An undervoltage flag sets only after its "below" comparator has been high for UV_DET_CYC consecutive sampling edges. A shorter pulse has no effect on the mode, and the count restarts from zero once the comparator drops.
- R3: A set core-supply flag moves the block to power-off from any mode, whatever the I/O supply and the standby pin are doing.
- R4: While the I/O-supply flag is set and the core supply is healthy, the block is in standby, whatever the level of the standby pin.
- R5: From power-off the block moves only to standby, and only after the core-supply flag has cleared. It never goes straight to normal.
- R6: With no flag set, a debounced standby pin of 1 selects normal and a debounced standby pin of 0 selects standby.
- R7: After the I/O-supply flag clears, the block goes to normal if the pin is high and stays in standby if the pin is low.
- R8: `pwr_on_o` is 0 after reset. It sets when the block leaves power-off. It clears when the block leaves normal for standby or power-off. Any other transition leaves it unchanged.
- R9: A pin level takes effect only after it has been stable for DB_NORM_CYC sampling edges in normal mode, or DB_LP_CYC edges in standby and power-off. Shorter pulses are ignored.
- R10: In power-off `rxd_o` is 1 and `err_n_o` is 0. In standby `rxd_o` is 1. In normal `rxd_o` follows `rxd_i` and `err_n_o` follows `err_n_i`.
- R11: After reset the block is in power-off with both undervoltage flags set. The flags clear only through the recovery filter.
- R12: A flag clears only after its "above" comparator has been high for UV_REC_CYC consecutive sampling edges. A shorter pulse leaves the flag and the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stby_n_i | input | 1 | Host standby pin, 1 requests normal (asynchronous) |
| core_below_i | input | 1 | Core supply below detection threshold (asynchronous) |
| core_above_i | input | 1 | Core supply above recovery threshold (asynchronous) |
| io_below_i | input | 1 | I/O supply below detection threshold (asynchronous) |
| io_above_i | input | 1 | I/O supply above recovery threshold (asynchronous) |
| rxd_i | input | 1 | Receive data from the receiver |
| err_n_i | input | 1 | Active-low error indication from the fault logic |
| mode_o | output | 2 | Current mode, encoded as in R1 |
| tx_allow_o | output | 1 | Transmitter may drive the bus |
| rx_allow_o | output | 1 | Receiver is active |
| term_gnd_o | output | 1 | Bus terminated to ground |
| bus_hiz_o | output | 1 | Bus left high-impedance |
| pwr_on_o | output | 1 | Power-on status flag |
| rxd_o | output | 1 | Receive data toward the host |
| err_n_o | output | 1 | Error indication toward the host |

## Verification
The risky coincidence is a filter decision and a debounced pin change landing on the same edge, for example an I/O fault maturing while the pin is moving to high. The priority order then has to win. A second case is a core fault maturing in the same cycle that power-off would be exited. The bench provokes these by holding a supply fault while it toggles the pin, and by driving random single-input changes with mixed filter lengths. After each change it waits for the inputs to settle and compares the mode, the enables, the power-on flag and the host-side outputs with values computed from the priority rules. Directed pulses one edge shorter than each filter window check that no decision is taken early.

// File: rtl/xcvr_mode_pkg.sv
package xcvr_mode_pkg;

   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_STBY = 2'b01,
      MODE_NORM = 2'b10
   } xcvr_mode_e;

   // width of a counter that runs from 0 to lim-1
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim);
   endfunction

endpackage

// File: rtl/xcvr_sync_chain.sv
module xcvr_sync_chain #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xcvr_sync_chain: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/xcvr_uv_filter.sv
module xcvr_uv_filter
   import xcvr_mode_pkg::*;
#(
   parameter int unsigned DET_CYC = 16,
   parameter int unsigned REC_CYC = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic below_i,
   input  logic above_i,
   output logic uv_flag_o
);

   if (DET_CYC < 1 || REC_CYC < 1) begin : g_bad_window
      $error("xcvr_uv_filter: filter windows must be at least 1");
   end

   localparam int unsigned MAX_CYC = (DET_CYC > REC_CYC) ? DET_CYC : REC_CYC;
   localparam int unsigned CW      = cnt_width(MAX_CYC);

   logic          flag_q;
   logic [CW-1:0] cnt_q;
   logic          watch;
   logic [CW-1:0] lim_m1;

   // a set flag waits for recovery, a clear flag waits for a fault
   assign watch  = flag_q ? above_i : below_i;
   assign lim_m1 = flag_q ? CW'(REC_CYC - 1) : CW'(DET_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b1;
         cnt_q  <= '0;
      end else if (!watch) begin
         cnt_q  <= '0;
      end else if (cnt_q == lim_m1) begin
         flag_q <= ~flag_q;
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign uv_flag_o = flag_q;

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_m1);
   p_set_needs_below_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(below_i));
   p_clear_needs_above_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q) |-> $past(above_i));

endmodule

// File: rtl/xcvr_pin_debounce.sv
module xcvr_pin_debounce
   import xcvr_mode_pkg::*;
#(
   parameter int unsigned NORM_CYC = 4,
   parameter int unsigned LP_CYC   = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   input  logic fast_i,
   output logic level_o
);

   if (NORM_CYC < 1 || LP_CYC < 1) begin : g_bad_window
      $error("xcvr_pin_debounce: debounce windows must be at least 1");
   end

   localparam int unsigned MAX_CYC = (NORM_CYC > LP_CYC) ? NORM_CYC : LP_CYC;
   localparam int unsigned CW      = cnt_width(MAX_CYC);

   logic          level_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_m1;

   assign lim_m1 = fast_i ? CW'(NORM_CYC - 1) : CW'(LP_CYC - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         cnt_q   <= '0;
      end else if (pin_i == level_q) begin
         cnt_q   <= '0;
      end else if (cnt_q >= lim_m1) begin
         level_q <= pin_i;
         cnt_q   <= '0;
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   assign level_o = level_q;

   p_db_follows_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q != $past(level_q)) |-> ($past(pin_i) == level_q));

endmodule

// File: rtl/xcvr_mode_ctrl.sv
module xcvr_mode_ctrl
   import xcvr_mode_pkg::*;
#(
   parameter int unsigned UV_DET_CYC  = 16,
   parameter int unsigned UV_REC_CYC  = 24,
   parameter int unsigned DB_NORM_CYC = 4,
   parameter int unsigned DB_LP_CYC   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       stby_n_i,
   input  logic       core_below_i,
   input  logic       core_above_i,
   input  logic       io_below_i,
   input  logic       io_above_i,
   input  logic       rxd_i,
   input  logic       err_n_i,
   output logic [1:0] mode_o,
   output logic       tx_allow_o,
   output logic       rx_allow_o,
   output logic       term_gnd_o,
   output logic       bus_hiz_o,
   output logic       pwr_on_o,
   output logic       rxd_o,
   output logic       err_n_o
);

   localparam int unsigned N_ASYNC = 5;

   logic [N_ASYNC-1:0] raw_in, syn_in;
   logic               core_uv, io_uv, stby_db;
   xcvr_mode_e         mode_q, mode_d;
   logic               pwr_on_q;

   assign raw_in = {stby_n_i, io_above_i, io_below_i, core_above_i, core_below_i};

   xcvr_sync_chain #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d_i (raw_in), .q_o (syn_in)
   );

   xcvr_uv_filter #(.DET_CYC(UV_DET_CYC), .REC_CYC(UV_REC_CYC)) u_core_filt (
      .clk (clk), .rst_n (rst_n),
      .below_i (syn_in[0]), .above_i (syn_in[1]), .uv_flag_o (core_uv)
   );

   xcvr_uv_filter #(.DET_CYC(UV_DET_CYC), .REC_CYC(UV_REC_CYC)) u_io_filt (
      .clk (clk), .rst_n (rst_n),
      .below_i (syn_in[2]), .above_i (syn_in[3]), .uv_flag_o (io_uv)
   );

   xcvr_pin_debounce #(.NORM_CYC(DB_NORM_CYC), .LP_CYC(DB_LP_CYC)) u_pin_db (
      .clk (clk), .rst_n (rst_n), .pin_i (syn_in[4]),
      .fast_i (mode_q == MODE_NORM), .level_o (stby_db)
   );

   // priority: core fault, exit from off, I/O fault, host pin
   always_comb begin
      if (core_uv)                 mode_d = MODE_OFF;
      else if (mode_q == MODE_OFF) mode_d = MODE_STBY;
      else if (io_uv)              mode_d = MODE_STBY;
      else if (stby_db)            mode_d = MODE_NORM;
      else                         mode_d = MODE_STBY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_OFF;
         pwr_on_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         if (mode_q == MODE_OFF && mode_d != MODE_OFF)
            pwr_on_q <= 1'b1;
         else if (mode_q == MODE_NORM && mode_d != MODE_NORM)
            pwr_on_q <= 1'b0;
      end
   end

   assign mode_o     = mode_q;
   assign tx_allow_o = (mode_q == MODE_NORM);
   assign rx_allow_o = (mode_q == MODE_NORM);
   assign term_gnd_o = (mode_q == MODE_STBY);
   assign bus_hiz_o  = (mode_q == MODE_OFF);
   assign pwr_on_o   = pwr_on_q;
   assign rxd_o      = (mode_q == MODE_NORM) ? rxd_i : 1'b1;
   assign err_n_o    = (mode_q == MODE_OFF) ? 1'b0 : err_n_i;

   p_legal_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({mode_q == MODE_OFF, mode_q == MODE_STBY, mode_q == MODE_NORM}));
   p_core_forces_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      core_uv |=> (mode_q == MODE_OFF));
   p_io_forces_stby_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_uv && io_uv && mode_q != MODE_OFF) |=> (mode_q == MODE_STBY));
   p_off_exit_stby_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OFF) |=> (mode_q != MODE_NORM));
   p_pin_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!core_uv && !io_uv && mode_q != MODE_OFF)
      |=> (mode_q == ($past(stby_db) ? MODE_NORM : MODE_STBY)));
   p_pwron_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == MODE_OFF && mode_q != MODE_OFF) |-> pwr_on_q);
   p_pwron_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_q) == MODE_NORM && mode_q != MODE_NORM) |-> !pwr_on_q);

endmodule

// File: tb/xcvr_mode_ctrl_test.sv
module xcvr_mode_ctrl_test;

   localparam int DET = 16;
   localparam int REC = 24;
   localparam int DBN = 4;
   localparam int DBL = 8;
   localparam int SETTLE = 60;
   localparam logic [1:0] M_OFF = 2'b00, M_STBY = 2'b01, M_NORM = 2'b10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic stby_n_i = 1'b0;
   logic core_below_i = 1'b0, core_above_i = 1'b0;
   logic io_below_i = 1'b0, io_above_i = 1'b0;
   logic rxd_i = 1'b1, err_n_i = 1'b1;
   logic [1:0] mode_o;
   logic tx_allow_o, rx_allow_o, term_gnd_o, bus_hiz_o, pwr_on_o, rxd_o, err_n_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit core_ok = 1'b0, io_ok = 1'b0, pin = 1'b0;
   logic [1:0] exp_m = M_OFF;
   bit exp_p = 1'b0;

   always #2 clk = ~clk;

   xcvr_mode_ctrl #(
      .UV_DET_CYC(DET), .UV_REC_CYC(REC), .DB_NORM_CYC(DBN), .DB_LP_CYC(DBL),
      .SYNC_STAGES(2)
   ) uut (
      .clk(clk), .rst_n(rst_n), .stby_n_i(stby_n_i),
      .core_below_i(core_below_i), .core_above_i(core_above_i),
      .io_below_i(io_below_i), .io_above_i(io_above_i),
      .rxd_i(rxd_i), .err_n_i(err_n_i), .mode_o(mode_o),
      .tx_allow_o(tx_allow_o), .rx_allow_o(rx_allow_o), .term_gnd_o(term_gnd_o),
      .bus_hiz_o(bus_hiz_o), .pwr_on_o(pwr_on_o), .rxd_o(rxd_o), .err_n_o(err_n_o)
   );

   function automatic logic [1:0] want_mode(input bit c_ok, input bit i_ok, input bit p);
      if (!c_ok)      return M_OFF;
      else if (!i_ok) return M_STBY;
      else if (p)     return M_NORM;
      else            return M_STBY;
   endfunction

   function automatic bit want_pwr(input logic [1:0] from, input logic [1:0] to, input bit cur);
      if (from == M_OFF && to != M_OFF)        return 1'b1;
      else if (from == M_NORM && to != M_NORM) return 1'b0;
      else                                     return cur;
   endfunction

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive_core(input bit good);
      core_ok = good; core_below_i = !good; core_above_i = good;
   endtask

   task automatic drive_io(input bit good);
      io_ok = good; io_below_i = !good; io_above_i = good;
   endtask

   // wait for all filters, then compare every output with the rules
   task automatic settle_check(input string tag);
      logic [1:0] nm;
      wait_n(SETTLE);
      nm = want_mode(core_ok, io_ok, pin);
      exp_p = want_pwr(exp_m, nm, exp_p);
      exp_m = nm;
      rxd_i = 1'($urandom); err_n_i = 1'($urandom);
      wait_n(1);
      chk({tag, " mode R1"}, mode_o, exp_m);
      chk({tag, " pwr_on R8"}, pwr_on_o, exp_p);
      chk({tag, " tx_allow R1"}, tx_allow_o, exp_m == M_NORM);
      chk({tag, " term_gnd R1"}, term_gnd_o, exp_m == M_STBY);
      chk({tag, " bus_hiz R1"}, bus_hiz_o, exp_m == M_OFF);
      chk({tag, " rxd R10"}, rxd_o, (exp_m == M_NORM) ? rxd_i : 1'b1);
      chk({tag, " err_n R10"}, err_n_o, (exp_m == M_OFF) ? 1'b0 : err_n_i);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      bit seen_off_exit;
      void'($urandom(32'd20240611));
      wait_n(4);
      rst_n = 1'b1;
      wait_n(1);
      // R11 reset state
      chk("R11 reset mode", mode_o, M_OFF);
      chk("R11 reset pwr_on", pwr_on_o, 1'b0);
      chk("R1 reset bus_hiz", bus_hiz_o, 1'b1);
      chk("R10 reset rxd", rxd_o, 1'b1);
      chk("R10 reset err_n", err_n_o, 1'b0);

      // I/O healthy, pin high, core only briefly above the recovery threshold
      drive_io(1'b1); pin = 1'b1; stby_n_i = 1'b1;
      wait_n(SETTLE);
      core_above_i = 1'b1;
      wait_n(REC - 1);
      core_above_i = 1'b0;
      wait_n(SETTLE);
      chk("R12 short recovery pulse", mode_o, M_OFF);

      // R5: first mode after power-off must be standby
      drive_core(1'b1);
      seen_off_exit = 1'b0;
      for (int i = 0; i < REC + 20; i++) begin
         wait_n(1);
         if (!seen_off_exit && mode_o != M_OFF) begin
            seen_off_exit = 1'b1;
            chk("R5 first mode after off", mode_o, M_STBY);
         end
      end
      chk("R5 off was left", seen_off_exit, 1'b1);
      settle_check("R6 pin high normal");
      chk("R8 set after off", pwr_on_o, 1'b1);

      // R2 short fault pulses on each supply
      io_above_i = 1'b0; io_below_i = 1'b1;
      wait_n(DET - 1);
      drive_io(1'b1);
      wait_n(SETTLE);
      chk("R2 short io pulse", mode_o, M_NORM);
      core_above_i = 1'b0; core_below_i = 1'b1;
      wait_n(DET - 1);
      drive_core(1'b1);
      wait_n(SETTLE);
      chk("R2 short core pulse", mode_o, M_NORM);

      // R9 short pin pulse in normal
      stby_n_i = 1'b0;
      wait_n(DBN - 1);
      stby_n_i = 1'b1;
      wait_n(SETTLE);
      chk("R9 short pin pulse normal", mode_o, M_NORM);

      pin = 1'b0; stby_n_i = 1'b0;
      settle_check("R6 pin low standby");
      chk("R8 cleared leaving normal", pwr_on_o, 1'b0);

      // R9 pulse long enough for normal but short for standby
      stby_n_i = 1'b1;
      wait_n(DBL - 1);
      stby_n_i = 1'b0;
      wait_n(SETTLE);
      chk("R9 short pin pulse standby", mode_o, M_STBY);

      pin = 1'b1; stby_n_i = 1'b1;
      settle_check("R6 back to normal");
      chk("R8 kept standby to normal", pwr_on_o, 1'b0);

      // R4 I/O fault with pin high, pin toggling during the fault
      drive_io(1'b0);
      settle_check("R4 io fault pin high");
      stby_n_i = 1'b0; wait_n(SETTLE); stby_n_i = 1'b1; wait_n(SETTLE);
      chk("R4 pin toggle during io fault", mode_o, M_STBY);
      drive_io(1'b1);
      settle_check("R7 io recovery pin high");
      pin = 1'b0; stby_n_i = 1'b0;
      settle_check("R6 pin low");
      drive_io(1'b0);
      settle_check("R4 io fault pin low");
      drive_io(1'b1);
      settle_check("R7 io recovery pin low");

      // R3 core fault from normal and from standby
      pin = 1'b1; stby_n_i = 1'b1;
      settle_check("R6 normal before core fault");
      drive_core(1'b0);
      settle_check("R3 core fault from normal");
      drive_core(1'b1);
      settle_check("R5 core recovery");
      drive_io(1'b0);
      settle_check("R4 io fault before core fault");
      drive_core(1'b0);
      settle_check("R3 core fault from standby");
      drive_core(1'b1);
      settle_check("R5 recovery with io fault");
      drive_io(1'b1);
      settle_check("R7 io recovery after off");

      // constrained random: one input changes per step
      for (int step = 0; step < 40; step++) begin
         case ($urandom % 3)
            0: drive_core(!core_ok);
            1: drive_io(!io_ok);
            default: begin pin = !pin; stby_n_i = pin; end
         endcase
         settle_check("random step R3 R4 R6 R7");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule